// File: doc/BRIEF.md
# Wake-up External Interrupt Controller

The controller watches 28 external wake-up lines that are already synchronous to its clock. Software programs a trigger condition for each line: low level, high level, falling edge, rising edge or both edges. Adjacent line pairs share one trigger field. When a line meets its condition, the block sets a sticky pending bit for that line. Software clears a pending bit by writing a one to it.

A per-line mask gates the pending bits onto four parent interrupt outputs. Each output covers a fixed run of lines, and the runs differ in size. The mask only affects the parent outputs. A masked line still records its events, so software can find out what happened while the line was blocked.

Access uses a small register port with 32-bit data and a two-bit word address. A write takes effect on the clock edge where the write-enable is sampled. Read data is combinational from the address.

Top module: `wkint_ctrl`

## Requirements
- R1: After reset, every trigger field reads 0, every mask bit reads 1, every pending bit reads 0 and all four parent outputs are low.
- R2: Word address 0 holds the trigger fields for lines 0 to 15 and word address 1 holds those for lines 16 to 27. Line n uses the 4-bit field at bit 4*((n mod 16)/2), so lines 2k and 2k+1 share one field.
- R3: Trigger code 0 (low level) and code 1 (high level) set the pending bit on every clock edge at which the level is present. A pending bit cleared while its level persists is set again.
- R4: Trigger codes 2 (falling), 4 (rising) and 6 (both) compare the line with its value one clock earlier and set pending only on a matching change. A level held steady does not set pending again after a clear.
- R5: A trigger field holding any value other than 0, 1, 2, 4 or 6 never sets pending.
- R6: A write to word address 3 clears each pending bit whose data bit is 1 and leaves each pending bit whose data bit is 0 unchanged.
- R7: If a trigger event and a clear of the same pending bit fall on the same clock edge, the pending bit ends up set.
- R8: Pending bits record events whatever the mask holds. Word address 2 holds the mask in bits 27:0, and a 1 blocks the line from its parent output only.
- R9: Each parent output is the OR of (pending AND NOT mask) over its range of lines. Bit 0 covers lines 0-3, bit 1 covers lines 4-11, bit 2 covers lines 12-19 and bit 3 covers lines 20-27.
- R10: The mask and pending words read 0 in bits 31:28. The trigger words read back all 32 written bits, and the spare fields at bits 31:24 of word address 1 affect no line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 28 | Wake-up lines, synchronous to clk_i |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0/1 trigger, 2 mask, 3 pending |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 4 | Parent interrupt outputs, one per line group |

## Verification
The bench targets the group boundaries at lines 3/4, 11/12, 19/20 and 27. A design with an off-by-one range would raise the wrong parent output. It also places edge and level stimulus on both lines of a shared field and on the upper configuration word, which catches a field-index error because the event lands on the wrong line.

The bench clears a pending bit while its level is still present. This exposes a design that lets the clear win over the set, or one that sets pending only once per level. Undefined trigger codes, including codes with the top bit set, are exercised to catch a decoder that looks at only three bits. Masked lines are driven to confirm that their events still reach the pending register while the parent output stays low.

// File: rtl/wkint_pkg.sv
package wkint_pkg;
  localparam int unsigned LINES         = 28;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned FIELD_W       = 4;
  localparam int unsigned GROUPS        = 4;
  localparam int unsigned FIRST_GROUP_W = 4;
  localparam int unsigned GROUP_W       = 8;
  localparam int unsigned ADDR_W        = 2;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG_LO = 2'd0,
    ADDR_CFG_HI = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_PEND   = 2'd3
  } addr_e;

  // first line of group g; group 0 is narrower than the rest
  function automatic int unsigned grp_lo(int unsigned g);
    return (g == 0) ? 0 : FIRST_GROUP_W + GROUP_W * (g - 1);
  endfunction

  function automatic int unsigned grp_hi(int unsigned g);
    return grp_lo(g + 1) - 1;
  endfunction
endpackage

// File: rtl/wkint_regs.sv
module wkint_regs
  import wkint_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES,
  parameter int unsigned DATA_W    = REG_W,
  parameter int unsigned FLD_W     = FIELD_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                cfg_lo_o,
  output logic [DATA_W-1:0]                cfg_hi_o,
  output logic [NUM_LINES-1:0]             mask_o,
  output logic [NUM_LINES-1:0][FLD_W-1:0]  trig_o
);
  localparam int unsigned FIELDS_PER_REG = DATA_W / FLD_W;

  logic [DATA_W-1:0]    cfg_lo_q, cfg_hi_q;
  logic [NUM_LINES-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '1;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CFG_LO: cfg_lo_q <= wdata_i;
        ADDR_CFG_HI: cfg_hi_q <= wdata_i;
        ADDR_MASK:   mask_q   <= wdata_i[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  // two lines per field; fields past the first word spill into the second
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_field
    localparam int unsigned FIDX = n / 2;
    if (FIDX < FIELDS_PER_REG) begin : g_lo
      assign trig_o[n] = cfg_lo_q[FIDX*FLD_W +: FLD_W];
    end else begin : g_hi
      assign trig_o[n] = cfg_hi_q[(FIDX-FIELDS_PER_REG)*FLD_W +: FLD_W];
    end
  end

  assign cfg_lo_o = cfg_lo_q;
  assign cfg_hi_o = cfg_hi_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/wkint_detect.sv
module wkint_detect
  import wkint_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES,
  parameter int unsigned FLD_W     = FIELD_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_LINES-1:0]            line_i,
  input  logic [NUM_LINES-1:0][FLD_W-1:0] trig_i,
  output logic [NUM_LINES-1:0]            hit_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_i;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic fell, rose;
    assign fell = prev_q[n] & ~line_i[n];
    assign rose = ~prev_q[n] & line_i[n];

    always_comb begin
      case (trig_i[n])
        TRIG_LOW:  hit_o[n] = ~line_i[n];
        TRIG_HIGH: hit_o[n] = line_i[n];
        TRIG_FALL: hit_o[n] = fell;
        TRIG_RISE: hit_o[n] = rose;
        TRIG_BOTH: hit_o[n] = fell | rose;
        default:   hit_o[n] = 1'b0;
      endcase
    end

    // R5: reserved codes stay silent
    assert_undef_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(trig_i[n] inside {TRIG_LOW, TRIG_HIGH, TRIG_FALL, TRIG_RISE, TRIG_BOTH})
        |-> !hit_o[n]);
  end
endmodule

// File: rtl/wkint_pend.sv
module wkint_pend
  import wkint_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q;

  // set dominates a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
endmodule

// File: rtl/wkint_group_or.sv
module wkint_group_or
  import wkint_pkg::*;
#(
  parameter int unsigned NUM_LINES  = LINES,
  parameter int unsigned NUM_GROUPS = GROUPS
) (
  input  logic [NUM_LINES-1:0]  active_i,
  output logic [NUM_GROUPS-1:0] irq_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO = grp_lo(g);
    localparam int unsigned HI = grp_hi(g);
    assign irq_o[g] = |active_i[HI:LO];
  end
endmodule

// File: rtl/wkint_ctrl.sv
module wkint_ctrl
  import wkint_pkg::*;
#(
  parameter int unsigned NUM_LINES  = LINES,
  parameter int unsigned DATA_W     = REG_W,
  parameter int unsigned NUM_GROUPS = GROUPS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  line_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [DATA_W-1:0]                 cfg_lo, cfg_hi;
  logic [NUM_LINES-1:0]              mask, pend, hit, clr;
  logic [NUM_LINES-1:0][FIELD_W-1:0] trig;
  logic [DATA_W-1:0]                 mask_ext, pend_ext;

  wkint_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .FLD_W(FIELD_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_lo_o(cfg_lo),
    .cfg_hi_o(cfg_hi),
    .mask_o  (mask),
    .trig_o  (trig)
  );

  wkint_detect #(.NUM_LINES(NUM_LINES), .FLD_W(FIELD_W)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .trig_i(trig),
    .hit_o (hit)
  );

  assign clr = (reg_we_i && reg_addr_i == ADDR_PEND) ? reg_wdata_i[NUM_LINES-1:0] : '0;

  wkint_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (clr),
    .pend_o(pend)
  );

  wkint_group_or #(.NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_GROUPS)) u_grp (
    .active_i(pend & ~mask),
    .irq_o   (irq_o)
  );

  always_comb begin
    mask_ext = '0;
    pend_ext = '0;
    mask_ext[NUM_LINES-1:0] = mask;
    pend_ext[NUM_LINES-1:0] = pend;
    case (reg_addr_i)
      ADDR_CFG_LO: reg_rdata_o = cfg_lo;
      ADDR_CFG_HI: reg_rdata_o = cfg_hi;
      ADDR_MASK:   reg_rdata_o = mask_ext;
      default:     reg_rdata_o = pend_ext;
    endcase
  end

  // R9: nothing unmasked pending means every parent is quiet
  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~mask) == '0) |-> (irq_o == '0));

  // R9: any unmasked pending line drives some parent
  assert_irq_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~mask) != '0) |-> (irq_o != '0));
endmodule

// File: tb/wkint_ctrl_tb.sv
`timescale 1ns/1ps
module wkint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] line = '1;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wkint_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic int grp_of(input int n);
    return (n < 4) ? 0 : (n < 12) ? 1 : (n < 20) ? 2 : 3;
  endfunction

  // R2 field placement, independent of RTL
  task automatic set_trig(input int n, input logic [3:0] code);
    logic [31:0] v;
    logic [1:0]  ra;
    int pos;
    ra  = (n < 16) ? 2'd0 : 2'd1;
    pos = 4 * ((n % 16) / 2);
    rd(ra, v);
    v[pos +: 4] = code;
    wr(ra, v);
  endtask

  task automatic pulse_low(input logic [27:0] sel);
    @(negedge clk); line = line & ~sel;
    @(negedge clk); line = line | sel;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 cfg_lo", v, 0);
    rd(1, v); chk("R1 cfg_hi", v, 0);
    rd(2, v); chk("R1 mask", v, 32'h0FFF_FFFF);
    rd(3, v); chk("R1 pend", v, 0);
    chk("R1 irq", {28'd0, irq}, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    // low level, held: set wins over clear, re-asserts
    @(negedge clk); line[9] = 1'b0;
    @(negedge clk);
    rd(3, v); chk("R3 low level sets", v, 32'h200);
    wr(3, 32'h200);
    rd(3, v); chk("R7 set beats clear", v, 32'h200);
    wr(3, 32'h200);
    rd(3, v); chk("R3 re-asserts while low", v, 32'h200);
    chk("R8 masked irq low", {28'd0, irq}, 0);
    @(negedge clk); line[9] = 1'b1;
    wr(3, 32'h200);
    rd(3, v); chk("R6 cleared after release", v, 0);
    // high level on shared pair 2/3
    set_trig(2, 4'd1);
    @(negedge clk);
    rd(3, v); chk("R2 pair 2/3 high level", v, 32'h0C);
    set_trig(3, 4'd0);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); chk("R3 restore low idle", v, 0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    set_trig(20, 4'd4);
    rd(1, v); chk("R2 hi word field", v, 32'h0000_0400);
    @(negedge clk); line[20] = 1'b0;
    @(negedge clk);
    rd(3, v); chk("R4 rise ignores fall", v, 0);
    line[20] = 1'b1;
    @(negedge clk);
    rd(3, v); chk("R4 rising edge", v, 32'h0010_0000);
    wr(3, 32'h0010_0000);
    @(negedge clk);
    rd(3, v); chk("R4 no re-set on held level", v, 0);
    set_trig(21, 4'd2);
    @(negedge clk); line[21] = 1'b0;
    @(negedge clk);
    rd(3, v); chk("R4 falling on shared line 21", v, 32'h0020_0000);
    line[21] = 1'b1;
    @(negedge clk);
    rd(3, v); chk("R4 falling ignores rise", v, 32'h0020_0000);
    wr(3, 32'hFFFF_FFFF);
    set_trig(20, 4'd6);
    @(negedge clk); line[20] = 1'b0;
    @(negedge clk);
    rd(3, v); chk("R4 both: fall", v, 32'h0010_0000);
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk); line[20] = 1'b1;
    @(negedge clk);
    rd(3, v); chk("R4 both: rise", v, 32'h0010_0000);
    set_trig(20, 4'd0);
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_undef;
    logic [31:0] v;
    logic [3:0] codes [5] = '{4'd3, 4'd5, 4'd7, 4'd8, 4'd14};
    foreach (codes[i]) begin
      set_trig(0, codes[i]);
      @(negedge clk); line[1:0] = 2'b00;
      @(negedge clk);
      @(negedge clk); line[1:0] = 2'b11;
      @(negedge clk);
      rd(3, v); chk($sformatf("R5 code %0d silent", codes[i]), v, 0);
    end
    set_trig(0, 4'd0);
  endtask

  task automatic t_groups;
    logic [31:0] v;
    int lines_list [8] = '{0, 3, 4, 11, 12, 19, 20, 27};
    wr(2, 32'h0);
    chk("R9 idle irq", {28'd0, irq}, 0);
    foreach (lines_list[i]) begin
      int n;
      n = lines_list[i];
      pulse_low(28'd1 << n);
      rd(3, v); chk($sformatf("R3 pend line %0d", n), v, 32'd1 << n);
      chk($sformatf("R9 group line %0d", n), {28'd0, irq}, 32'd1 << grp_of(n));
      wr(2, 32'd1 << n);
      chk($sformatf("R8 masked irq line %0d", n), {28'd0, irq}, 0);
      rd(3, v); chk($sformatf("R8 pend kept line %0d", n), v, 32'd1 << n);
      wr(2, 32'h0);
      wr(3, 32'd1 << n);
      chk($sformatf("R9 irq drops line %0d", n), {28'd0, irq}, 0);
    end
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    pulse_low(28'h60);
    rd(3, v); chk("R8 masked lines latch", v, 32'h60);
    wr(3, 32'h20);
    rd(3, v); chk("R6 write-one clears bit 5 only", v, 32'h40);
    wr(3, 32'h0);
    rd(3, v); chk("R6 write-zero keeps", v, 32'h40);
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    rd(2, v); chk("R10 mask upper zero", v, 32'h0FFF_FFFF);
    wr(1, 32'hA500_0000);
    @(negedge clk);
    rd(1, v); chk("R10 spare field readback", v, 32'hA500_0000);
    rd(3, v); chk("R10 spare field inert", v, 0);
    wr(1, 32'h0);
    rd(3, v); chk("R10 pend upper zero", v, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_undef();
    t_groups();
    t_clear();
    t_regmap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule